// File: doc/BRIEF.md
# Privileged Trap and Status Register Unit

This block keeps the privilege state of one RISC-V hart that implements the Machine, Supervisor and User levels. The hypervisor level is absent. The unit holds the machine status word, the trap vectors, the exception program counters, the cause and trap-value registers, the delegation registers, and the interrupt enable and pending words. The supervisor status, enable and pending registers are not separate storage. They are masked windows onto the machine copies.

The commit stage drives the unit through four kinds of input:

- a CSR access port for reads and writes;
- a trap request carrying a cause, the faulting PC and a trap value;
- a one-cycle pulse for a machine return;
- a one-cycle pulse for a supervisor return.

In the same cycle as a trap request, the unit reports the handler address the fetch stage must redirect to. In the same cycle as a return pulse, it reports the address to resume at. It always reports the current privilege level. All state changes take effect on the next clock edge.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset the privilege output is Machine (2'b11) and every register reads as zero.
- R2: Machine registers use the standard addresses: status 0x300, exception delegation 0x302, interrupt delegation 0x303, enable 0x304, vector 0x305, epc 0x341, cause 0x342, tval 0x343, pending 0x344. Writes keep only the writable bits, with zeros elsewhere:
  - status keeps bits 1,3,5,7,8,12:11 (mask 0x19AA);
  - enable keeps 0xAAA;
  - pending keeps 0x222;
  - interrupt delegation keeps 0x222;
  - exception delegation keeps 0xF7FF.
- R3: The supervisor windows are status 0x100, enable 0x104, pending 0x144. The status window reads and writes only bits 1,5,8 (0x122) of the machine status. The enable window reads and writes bits 0x222 of the machine enable word. The pending window reads bits 0x222 and writes only bit 1. Supervisor vector 0x105, epc 0x141, cause 0x142 and tval 0x143 are plain registers.
- R4: An access is illegal in either of two cases: the address bits 9:8 exceed the current privilege, or the address is unknown. An illegal access raises csr_illegal in the same cycle and changes no state.
- R5: Writing the value 2'b10 to the previous-machine-privilege field (status bits 12:11) leaves that field unchanged.
- R6: A trap that is not delegated has the following effects on the next edge:
  - machine epc, cause and tval are loaded from the request;
  - bit 7 takes the value of bit 3, and bit 3 is cleared;
  - bits 12:11 take the old privilege;
  - the privilege becomes Machine.
- R7: A trap is delegated when three conditions hold: the privilege is S or U, the cause is below XLEN, and the exception delegation bit indexed by the cause is set. A delegated trap has the following effects:
  - supervisor epc, cause and tval are loaded from the request;
  - bit 5 takes the value of bit 1, and bit 1 is cleared;
  - bit 8 takes bit 0 of the old privilege;
  - the privilege becomes Supervisor.
- R8: A trap raised in Machine mode is never delegated, and it leaves the supervisor registers untouched.
- R9: While a trap is requested, trap_target shows the selected vector with its two low bits cleared.
- R10: A machine return has the following effects:
  - bit 3 takes bit 7;
  - the privilege takes bits 12:11;
  - bits 12:11 become User;
  - bit 7 becomes 1.
- R11: A supervisor return has the following effects:
  - bit 1 takes bit 5;
  - the privilege becomes {0, bit 8};
  - bit 8 is cleared;
  - bit 5 becomes 1.
- R12: When several events fall in the same cycle, only one takes effect. A trap beats both returns and the CSR write. A machine return beats a supervisor return. A return beats the CSR write. Every event that loses has no effect.
- R13: ret_pc shows the supervisor epc when the supervisor return pulse is high and the machine return pulse is low. In every other cycle it shows the machine epc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access valid |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data, masked view |
| csr_illegal | output | 1 | Access not permitted or unknown address |
| trap_req | input | 1 | Take a trap this cycle |
| trap_cause | input | XLEN | Exception cause code |
| trap_pc | input | XLEN | PC of the faulting instruction |
| trap_val | input | XLEN | Trap value |
| mret_pulse | input | 1 | Machine return pulse |
| sret_pulse | input | 1 | Supervisor return pulse |
| trap_target | output | XLEN | Handler address for the current request |
| ret_pc | output | XLEN | Resume address for the current return |
| priv_out | output | 2 | Current privilege level |

## Verification
The hardest state to reach is a delegated trap taken from User mode whose supervisor stacking can then be read back. Only Machine mode can arm the vector, the delegation bit and the status bits. The bench therefore arms these from Machine mode, then leaves through a machine return whose stacked privilege is User. It then raises the delegated cause. Supervisor mode can read the status window, but the machine copies are hidden from it. The bench reaches them again through a non-delegated trap, which leaves the supervisor fields alone. Collisions between events are built the same way: the bench first places the unit at the privilege where every colliding event is legal, then drives them in one cycle.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

  typedef logic [1:0] priv_t;

  localparam priv_t PRIV_U = 2'b00;
  localparam priv_t PRIV_S = 2'b01;
  localparam priv_t PRIV_M = 2'b11;

  // status word bit positions
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  // writable / visible masks (low 16 bits)
  localparam logic [15:0] MSK_STATUS  = 16'h19AA;
  localparam logic [15:0] MSK_SSTATUS = 16'h0122;
  localparam logic [15:0] MSK_MIE     = 16'h0AAA;
  localparam logic [15:0] MSK_SINT    = 16'h0222;
  localparam logic [15:0] MSK_SIP_WR  = 16'h0002;
  localparam logic [15:0] MSK_EDELEG  = 16'hF7FF;

  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_MEDELEG = 12'h302;
  localparam logic [11:0] A_MIDELEG = 12'h303;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_MEPC    = 12'h341;
  localparam logic [11:0] A_MCAUSE  = 12'h342;
  localparam logic [11:0] A_MTVAL   = 12'h343;
  localparam logic [11:0] A_MIP     = 12'h344;
  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_SIE     = 12'h104;
  localparam logic [11:0] A_STVEC   = 12'h105;
  localparam logic [11:0] A_SEPC    = 12'h141;
  localparam logic [11:0] A_SCAUSE  = 12'h142;
  localparam logic [11:0] A_STVAL   = 12'h143;
  localparam logic [11:0] A_SIP     = 12'h144;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_MSTATUS, SEL_SSTATUS, SEL_MEDELEG, SEL_MIDELEG,
    SEL_MIE, SEL_SIE, SEL_MTVEC, SEL_STVEC, SEL_MEPC, SEL_SEPC,
    SEL_MCAUSE, SEL_SCAUSE, SEL_MTVAL, SEL_STVAL, SEL_MIP, SEL_SIP
  } csr_sel_e;

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/csr_access_guard.sv
module csr_access_guard
  import trap_csr_pkg::*;
(
  input  logic        acc_en,
  input  logic [11:0] acc_addr,
  input  priv_t       cur_priv,
  output csr_sel_e    acc_sel,
  output logic        acc_illegal
);
  always_comb begin
    unique case (acc_addr)
      A_MSTATUS: acc_sel = SEL_MSTATUS;
      A_MEDELEG: acc_sel = SEL_MEDELEG;
      A_MIDELEG: acc_sel = SEL_MIDELEG;
      A_MIE:     acc_sel = SEL_MIE;
      A_MTVEC:   acc_sel = SEL_MTVEC;
      A_MEPC:    acc_sel = SEL_MEPC;
      A_MCAUSE:  acc_sel = SEL_MCAUSE;
      A_MTVAL:   acc_sel = SEL_MTVAL;
      A_MIP:     acc_sel = SEL_MIP;
      A_SSTATUS: acc_sel = SEL_SSTATUS;
      A_SIE:     acc_sel = SEL_SIE;
      A_STVEC:   acc_sel = SEL_STVEC;
      A_SEPC:    acc_sel = SEL_SEPC;
      A_SCAUSE:  acc_sel = SEL_SCAUSE;
      A_STVAL:   acc_sel = SEL_STVAL;
      A_SIP:     acc_sel = SEL_SIP;
      default:   acc_sel = SEL_NONE;
    endcase
  end

  // address bits 9:8 carry the lowest privilege allowed to touch the register
  assign acc_illegal = acc_en && ((acc_sel == SEL_NONE) || (acc_addr[9:8] > cur_priv));
endmodule

// File: rtl/csr_trap_router.sv
module csr_trap_router
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] cause,
  input  priv_t           cur_priv,
  input  logic [XLEN-1:0] edeleg,
  input  logic [XLEN-1:0] m_vec,
  input  logic [XLEN-1:0] s_vec,
  output logic            to_super,
  output logic [XLEN-1:0] target
);
  localparam int CIDX = $clog2(XLEN);

  logic in_range;
  assign in_range = (cause[XLEN-1:CIDX] == '0);
  assign to_super = (cur_priv != PRIV_M) && in_range && edeleg[cause[CIDX-1:0]];
  assign target   = (to_super ? s_vec : m_vec) & ~{{(XLEN-2){1'b0}}, 2'b11};
endmodule

// File: rtl/csr_status_next.sv
module csr_status_next
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] st_q,
  input  priv_t           priv_q,
  input  logic            take_m,
  input  logic            take_s,
  input  logic            do_mret,
  input  logic            do_sret,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_val,
  output logic [XLEN-1:0] st_d,
  output priv_t           priv_d
);
  always_comb begin
    st_d   = st_q;
    priv_d = priv_q;
    if (take_m) begin
      st_d[ST_MPIE]       = st_q[ST_MIE];
      st_d[ST_MIE]        = 1'b0;
      st_d[ST_MPP +: 2]   = priv_q;
      priv_d              = PRIV_M;
    end else if (take_s) begin
      st_d[ST_SPIE]       = st_q[ST_SIE];
      st_d[ST_SIE]        = 1'b0;
      st_d[ST_SPP]        = priv_q[0];
      priv_d              = PRIV_S;
    end else if (do_mret) begin
      st_d[ST_MIE]        = st_q[ST_MPIE];
      priv_d              = st_q[ST_MPP +: 2];
      st_d[ST_MPP +: 2]   = PRIV_U;
      st_d[ST_MPIE]       = 1'b1;
    end else if (do_sret) begin
      st_d[ST_SIE]        = st_q[ST_SPIE];
      priv_d              = {1'b0, st_q[ST_SPP]};
      st_d[ST_SPP]        = 1'b0;
      st_d[ST_SPIE]       = 1'b1;
    end else if (wr_en) begin
      st_d = wr_val;
      if (wr_val[ST_MPP +: 2] == 2'b10) st_d[ST_MPP +: 2] = st_q[ST_MPP +: 2];
    end
  end
endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  input  logic            trap_req,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_val,
  input  logic            mret_pulse,
  input  logic            sret_pulse,
  output logic [XLEN-1:0] trap_target,
  output logic [XLEN-1:0] ret_pc,
  output logic [1:0]      priv_out
);
  localparam logic [XLEN-1:0] M_STATUS  = {{(XLEN-16){1'b0}}, MSK_STATUS};
  localparam logic [XLEN-1:0] M_SSTATUS = {{(XLEN-16){1'b0}}, MSK_SSTATUS};
  localparam logic [XLEN-1:0] M_MIE     = {{(XLEN-16){1'b0}}, MSK_MIE};
  localparam logic [XLEN-1:0] M_SINT    = {{(XLEN-16){1'b0}}, MSK_SINT};
  localparam logic [XLEN-1:0] M_SIPWR   = {{(XLEN-16){1'b0}}, MSK_SIP_WR};
  localparam logic [XLEN-1:0] M_EDELEG  = {{(XLEN-16){1'b0}}, MSK_EDELEG};

  logic srst_n;
  csr_rst_sync #(.STAGES(2)) rsync_i (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  priv_t           priv_q, priv_d;
  logic [XLEN-1:0] mstatus_q, mstatus_d;
  logic [XLEN-1:0] medeleg_q, medeleg_d, mideleg_q, mideleg_d;
  logic [XLEN-1:0] mie_q, mie_d, mip_q, mip_d;
  logic [XLEN-1:0] mtvec_q, mtvec_d, stvec_q, stvec_d;
  logic [XLEN-1:0] mepc_q, mepc_d, sepc_q, sepc_d;
  logic [XLEN-1:0] mcause_q, mcause_d, scause_q, scause_d;
  logic [XLEN-1:0] mtval_q, mtval_d, stval_q, stval_d;

  csr_sel_e sel;
  logic     trap_to_s;

  csr_access_guard guard_i (
    .acc_en(csr_en), .acc_addr(csr_addr), .cur_priv(priv_q),
    .acc_sel(sel), .acc_illegal(csr_illegal)
  );

  csr_trap_router #(.XLEN(XLEN)) router_i (
    .cause(trap_cause), .cur_priv(priv_q), .edeleg(medeleg_q),
    .m_vec(mtvec_q), .s_vec(stvec_q), .to_super(trap_to_s), .target(trap_target)
  );

  // event arbitration: trap > mret > sret > csr write
  logic take_m, take_s, do_mret, do_sret, do_wr, state_en;
  assign take_m   = trap_req && !trap_to_s;
  assign take_s   = trap_req &&  trap_to_s;
  assign do_mret  = mret_pulse && !trap_req;
  assign do_sret  = sret_pulse && !mret_pulse && !trap_req;
  assign do_wr    = csr_en && csr_we && !csr_illegal && !trap_req && !mret_pulse && !sret_pulse;
  assign state_en = trap_req || do_mret || do_sret || do_wr;

  function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] old_v,
                                            input logic [XLEN-1:0] new_v,
                                            input logic [XLEN-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  logic            st_wr;
  logic [XLEN-1:0] st_wval;
  assign st_wr   = do_wr && ((sel == SEL_MSTATUS) || (sel == SEL_SSTATUS));
  assign st_wval = (sel == SEL_SSTATUS) ? merge(mstatus_q, csr_wdata, M_SSTATUS)
                                        : merge(mstatus_q, csr_wdata, M_STATUS);

  csr_status_next #(.XLEN(XLEN)) stnext_i (
    .st_q(mstatus_q), .priv_q(priv_q), .take_m(take_m), .take_s(take_s),
    .do_mret(do_mret), .do_sret(do_sret), .wr_en(st_wr), .wr_val(st_wval),
    .st_d(mstatus_d), .priv_d(priv_d)
  );

  // next state of the plain registers
  always_comb begin
    medeleg_d = medeleg_q;  mideleg_d = mideleg_q;
    mie_d     = mie_q;      mip_d     = mip_q;
    mtvec_d   = mtvec_q;    stvec_d   = stvec_q;
    mepc_d    = mepc_q;     sepc_d    = sepc_q;
    mcause_d  = mcause_q;   scause_d  = scause_q;
    mtval_d   = mtval_q;    stval_d   = stval_q;
    if (take_m) begin
      mepc_d = trap_pc;  mcause_d = trap_cause;  mtval_d = trap_val;
    end
    if (take_s) begin
      sepc_d = trap_pc;  scause_d = trap_cause;  stval_d = trap_val;
    end
    if (do_wr) begin
      unique case (sel)
        SEL_MEDELEG: medeleg_d = csr_wdata & M_EDELEG;
        SEL_MIDELEG: mideleg_d = csr_wdata & M_SINT;
        SEL_MIE:     mie_d     = csr_wdata & M_MIE;
        SEL_SIE:     mie_d     = merge(mie_q, csr_wdata, M_SINT);
        SEL_MIP:     mip_d     = csr_wdata & M_SINT;
        SEL_SIP:     mip_d     = merge(mip_q, csr_wdata, M_SIPWR);
        SEL_MTVEC:   mtvec_d   = csr_wdata;
        SEL_STVEC:   stvec_d   = csr_wdata;
        SEL_MEPC:    mepc_d    = csr_wdata;
        SEL_SEPC:    sepc_d    = csr_wdata;
        SEL_MCAUSE:  mcause_d  = csr_wdata;
        SEL_SCAUSE:  scause_d  = csr_wdata;
        SEL_MTVAL:   mtval_d   = csr_wdata;
        SEL_STVAL:   stval_d   = csr_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      priv_q   <= PRIV_M;
      mstatus_q <= '0;  medeleg_q <= '0;  mideleg_q <= '0;
      mie_q    <= '0;   mip_q    <= '0;
      mtvec_q  <= '0;   stvec_q  <= '0;
      mepc_q   <= '0;   sepc_q   <= '0;
      mcause_q <= '0;   scause_q <= '0;
      mtval_q  <= '0;   stval_q  <= '0;
    end else if (state_en) begin
      priv_q   <= priv_d;
      mstatus_q <= mstatus_d;  medeleg_q <= medeleg_d;  mideleg_q <= mideleg_d;
      mie_q    <= mie_d;    mip_q    <= mip_d;
      mtvec_q  <= mtvec_d;  stvec_q  <= stvec_d;
      mepc_q   <= mepc_d;   sepc_q   <= sepc_d;
      mcause_q <= mcause_d; scause_q <= scause_d;
      mtval_q  <= mtval_d;  stval_q  <= stval_d;
    end
  end

  // read view
  always_comb begin
    unique case (sel)
      SEL_MSTATUS: csr_rdata = mstatus_q;
      SEL_SSTATUS: csr_rdata = mstatus_q & M_SSTATUS;
      SEL_MEDELEG: csr_rdata = medeleg_q;
      SEL_MIDELEG: csr_rdata = mideleg_q;
      SEL_MIE:     csr_rdata = mie_q;
      SEL_SIE:     csr_rdata = mie_q & M_SINT;
      SEL_MIP:     csr_rdata = mip_q;
      SEL_SIP:     csr_rdata = mip_q & M_SINT;
      SEL_MTVEC:   csr_rdata = mtvec_q;
      SEL_STVEC:   csr_rdata = stvec_q;
      SEL_MEPC:    csr_rdata = mepc_q;
      SEL_SEPC:    csr_rdata = sepc_q;
      SEL_MCAUSE:  csr_rdata = mcause_q;
      SEL_SCAUSE:  csr_rdata = scause_q;
      SEL_MTVAL:   csr_rdata = mtval_q;
      SEL_STVAL:   csr_rdata = stval_q;
      default:     csr_rdata = '0;
    endcase
  end

  assign ret_pc   = (sret_pulse && !mret_pulse) ? sepc_q : mepc_q;
  assign priv_out = priv_q;

  // R1
  priv_encoding_chk: assert property (@(posedge clk) disable iff (!srst_n)
    priv_q != 2'b10);

  // R4
  illegal_no_effect_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (csr_en && csr_illegal && !trap_req && !mret_pulse && !sret_pulse)
    |=> ($stable(mstatus_q) && $stable(priv_q) && $stable(mtvec_q) && $stable(sepc_q)));

  // R6
  mtrap_entry_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (trap_req && priv_q == PRIV_M)
    |=> (priv_q == PRIV_M && mepc_q == $past(trap_pc) && !mstatus_q[ST_MIE]));

  // R7
  strap_entry_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (trap_req && trap_to_s)
    |=> (priv_q == PRIV_S && sepc_q == $past(trap_pc) && !mstatus_q[ST_SIE]));

  // R10
  mret_stack_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mret_pulse && !trap_req)
    |=> (priv_q == $past(mstatus_q[ST_MPP +: 2]) && mstatus_q[ST_MPP +: 2] == PRIV_U
         && mstatus_q[ST_MPIE]));

  // R11
  sret_stack_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sret_pulse && !mret_pulse && !trap_req)
    |=> (priv_q == {1'b0, $past(mstatus_q[ST_SPP])} && !mstatus_q[ST_SPP]
         && mstatus_q[ST_SPIE]));

endmodule

// File: tb/trap_csr_unit_tb_top.sv
module trap_csr_unit_tb_top;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic csr_en, csr_we, csr_illegal, trap_req, mret_pulse, sret_pulse;
  logic [11:0] csr_addr;
  logic [XLEN-1:0] csr_wdata, csr_rdata, trap_cause, trap_pc, trap_val, trap_target, ret_pc;
  logic [1:0] priv_out;

  always #10 clk = ~clk;  // 50 MHz

  trap_csr_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .trap_req(trap_req), .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_val(trap_val),
    .mret_pulse(mret_pulse), .sret_pulse(sret_pulse), .trap_target(trap_target),
    .ret_pc(ret_pc), .priv_out(priv_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [XLEN-1:0] cap_rd, cap_tgt, cap_ret;
  logic            cap_ill;

  task automatic chk(input string req, input string what, input logic [XLEN-1:0] got,
                     input logic [XLEN-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // one cycle of stimulus, starting just after a falling edge
  task automatic cyc(input logic tr, input logic [XLEN-1:0] cause, input logic [XLEN-1:0] pc,
                     input logic [XLEN-1:0] tv, input logic mr, input logic sr,
                     input logic en, input logic we, input logic [11:0] a,
                     input logic [XLEN-1:0] d);
    trap_req = tr; trap_cause = cause; trap_pc = pc; trap_val = tv;
    mret_pulse = mr; sret_pulse = sr;
    csr_en = en; csr_we = we; csr_addr = a; csr_wdata = d;
    #1;
    cap_rd = csr_rdata; cap_ill = csr_illegal; cap_tgt = trap_target; cap_ret = ret_pc;
    @(posedge clk);
    @(negedge clk);
    trap_req = 0; mret_pulse = 0; sret_pulse = 0; csr_en = 0; csr_we = 0;
    trap_cause = '0; trap_pc = '0; trap_val = '0; csr_addr = '0; csr_wdata = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, a, d);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [XLEN-1:0] exp);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, a, 0);
    chk(req, $sformatf("read %h", a), cap_rd, exp);
  endtask

  task automatic ill_chk(input string req, input logic [11:0] a);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, a, 0);
    chk(req, $sformatf("illegal %h", a), {63'd0, cap_ill}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R1", "priv after reset", {62'd0, priv_out}, 64'd3);
    rd_chk("R1", 12'h300, 64'h0);
    rd_chk("R1", 12'h305, 64'h0);
    rd_chk("R1", 12'h302, 64'h0);
    chk("R1", "legal access flag", {63'd0, cap_ill}, 64'd0);
  endtask

  task automatic t_rw;
    wr(12'h305, 64'h8000_0103); rd_chk("R2", 12'h305, 64'h8000_0103);
    wr(12'h300, '1);            rd_chk("R2", 12'h300, 64'h19AA);
    wr(12'h304, '1);            rd_chk("R2", 12'h304, 64'hAAA);
    wr(12'h344, '1);            rd_chk("R2", 12'h344, 64'h222);
    wr(12'h303, '1);            rd_chk("R2", 12'h303, 64'h222);
    ill_chk("R4", 12'h7C0);
  endtask

  task automatic t_alias;
    rd_chk("R3", 12'h100, 64'h122);
    wr(12'h100, 64'h0);  rd_chk("R3", 12'h300, 64'h1888);
    rd_chk("R3", 12'h104, 64'h222);
    wr(12'h104, 64'h0);  rd_chk("R3", 12'h304, 64'h888);
    wr(12'h344, 64'h0);  wr(12'h144, '1);
    rd_chk("R3", 12'h344, 64'h002);
    rd_chk("R3", 12'h144, 64'h002);
  endtask

  task automatic t_warl;
    wr(12'h300, 64'h1000); rd_chk("R5", 12'h300, 64'h1800);
    wr(12'h300, 64'h0800); rd_chk("R5", 12'h300, 64'h0800);
  endtask

  task automatic t_trap_m;
    wr(12'h302, '1);  rd_chk("R2", 12'h302, 64'hF7FF);
    wr(12'h105, 64'h4000_0201);
    wr(12'h300, 64'h0008);
    cyc(1, 64'd2, 64'h1234, 64'hBEEF, 0, 0, 0, 0, 0, 0);
    chk("R8", "target from M ignores delegation", cap_tgt, 64'h8000_0100);
    chk("R6", "priv after trap", {62'd0, priv_out}, 64'd3);
    rd_chk("R6", 12'h300, 64'h1880);
    rd_chk("R6", 12'h341, 64'h1234);
    rd_chk("R6", 12'h342, 64'd2);
    rd_chk("R6", 12'h343, 64'hBEEF);
    rd_chk("R8", 12'h142, 64'h0);
  endtask

  task automatic t_mret;
    wr(12'h302, 64'h100);
    wr(12'h341, 64'h2000);
    wr(12'h300, 64'h0080);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R13", "ret_pc on machine return", cap_ret, 64'h2000);
    chk("R10", "priv after machine return", {62'd0, priv_out}, 64'd0);
    ill_chk("R4", 12'h300);
    ill_chk("R4", 12'h100);
    wr(12'h305, 64'h55);
    cyc(1, 64'd2, 64'h2004, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "machine target from user", cap_tgt, 64'h8000_0100);
    chk("R6", "priv after user trap", {62'd0, priv_out}, 64'd3);
    rd_chk("R10", 12'h300, 64'h0080);
    rd_chk("R4", 12'h305, 64'h8000_0103);
    rd_chk("R6", 12'h341, 64'h2004);
  endtask

  task automatic t_deleg;
    wr(12'h300, 64'h0002);
    wr(12'h341, 64'h3000);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R10", "priv user before delegated trap", {62'd0, priv_out}, 64'd0);
    cyc(1, 64'd8, 64'h3004, 64'h77, 0, 0, 0, 0, 0, 0);
    chk("R9", "delegated target", cap_tgt, 64'h4000_0200);
    chk("R7", "priv after delegated trap", {62'd0, priv_out}, 64'd1);
    rd_chk("R7", 12'h100, 64'h20);
    rd_chk("R7", 12'h141, 64'h3004);
    rd_chk("R7", 12'h142, 64'd8);
    rd_chk("R7", 12'h143, 64'h77);
    ill_chk("R4", 12'h300);
  endtask

  task automatic t_sret;
    wr(12'h100, 64'h102);  rd_chk("R3", 12'h100, 64'h102);
    wr(12'h141, 64'h5000);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R13", "ret_pc on supervisor return", cap_ret, 64'h5000);
    chk("R11", "priv from SPP=1", {62'd0, priv_out}, 64'd1);
    rd_chk("R11", 12'h100, 64'h20);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R11", "priv from SPP=0", {62'd0, priv_out}, 64'd0);
    cyc(1, 64'd2, 64'h5100, 0, 0, 0, 0, 0, 0, 0);
    chk("R6", "back to machine", {62'd0, priv_out}, 64'd3);
    rd_chk("R11", 12'h100, 64'h22);
  endtask

  task automatic t_priority;
    wr(12'h341, 64'h6000);
    wr(12'h141, 64'h7000);
    wr(12'h300, 64'h0800);
    cyc(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R13", "ret_pc with both pulses", cap_ret, 64'h6000);
    chk("R12", "machine return wins", {62'd0, priv_out}, 64'd1);
    rd_chk("R12", 12'h100, 64'h0);
    cyc(1, 64'd2, 64'h6100, 0, 1, 0, 1, 1, 12'h141, 64'h1111);
    chk("R12", "trap wins over return", {62'd0, priv_out}, 64'd3);
    rd_chk("R12", 12'h341, 64'h6100);
    rd_chk("R12", 12'h141, 64'h7000);
    rd_chk("R12", 12'h300, 64'h0800);
    cyc(1, 64'd3, 64'h6200, 0, 0, 0, 1, 1, 12'h305, 64'h999);
    rd_chk("R12", 12'h305, 64'h8000_0103);
  endtask

  initial begin
    rst_n = 0;
    trap_req = 0; mret_pulse = 0; sret_pulse = 0; csr_en = 0; csr_we = 0;
    trap_cause = '0; trap_pc = '0; trap_val = '0; csr_addr = '0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_alias();
    t_warl();
    t_trap_m();
    t_mret();
    t_deleg();
    t_sret();
    t_priority();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule